// File: doc/BRIEF.md
# Vector-to-Scalar Reduction Sequencer

This block executes one element-wise integer operation over a vector of registers held in a private 32-entry, 32-bit register file. A request names a destination and two sources. Each operand has a register index, a vector flag and a register-class bit. The request also carries an element count, an opcode and a mapreduce control. After a start pulse the sequencer performs one element operation per clock, in ascending element order. Each result is written back before the next element reads its operands.

When the destination is a scalar and one source names the same register, that register acts as an accumulator. With mapreduce set, every element folds into it serially, so an add over a vector source yields the sum of all elements. With mapreduce clear, a scalar destination ends the loop after element 0. A vector destination always runs the full length.

Malformed requests are rejected with an illegal flag and cause no writes. These are unknown opcodes, operands of the condition class, and vector ranges that run past the last register. A load port fills registers while the sequencer is idle. A peek port reads any register at any time.

Top module: `red_reduce_seq`

## Requirements
- R1: With opcode 0 (add), a scalar destination equal to scalar source A, a vector source B and mapreduce set, the destination ends holding its old value plus registers B..B+VL-1, modulo 2^32.
- R2: With a scalar destination and mapreduce clear, exactly one element operation (element 0) is performed and done follows it.
- R3: Element operations occur in ascending order, one per cycle. Each reads register contents that include every write made by lower-numbered elements.
- R4: Opcode 1 (subtract, A minus B) also runs in accumulator mode, subtracting each vector element from the accumulator in turn, modulo 2^32.
- R5: Register-class bit 1 marks a condition-class operand. A request where any operand has class bit 1 raises illegal together with done and writes no register.
- R6: Opcode 7, or a vector operand whose base plus VL exceeds 32, raises illegal with done and writes nothing. A vector ending exactly at register 31 is legal.
- R7: With VL equal to 0, no register changes, illegal stays low, and done is high in the cycle right after the accepting edge.
- R8: With the vector flag set on the destination, element i writes register dst+i for every i below VL, whatever the mapreduce setting. Vector sources likewise read base+i, and scalar operands always use their base register.
- R9: Opcodes 2, 3 and 4 are bitwise AND, OR and XOR. Opcodes 5 and 6 are minimum and maximum under signed two's-complement comparison.
- R10: Done is a one-cycle pulse, high exactly N cycles after the accepting edge, where N is the number of element operations. Busy is high from the accepting edge until done falls.
- R11: A start pulse while busy is ignored, and so are changes of the request inputs during that time.
- R12: After reset all registers read zero and busy, done and illegal are low.
- R13: A load strobe while idle writes the given data into the given register. The peek port returns any register's contents combinationally.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted while idle |
| vl | input | 6 | Element count, 0 to 32 |
| opcode | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 min, 6 max, 7 reserved |
| dst_idx | input | 5 | Destination base register |
| dst_vec | input | 1 | Destination is a vector |
| dst_cls | input | 1 | Destination class (1 = condition class) |
| srca_idx | input | 5 | Source A base register |
| srca_vec | input | 1 | Source A is a vector |
| srca_cls | input | 1 | Source A class |
| srcb_idx | input | 5 | Source B base register |
| srcb_vec | input | 1 | Source B is a vector |
| srcb_cls | input | 1 | Source B class |
| mapreduce | input | 1 | Continue past element 0 for a scalar destination |
| ld_en | input | 1 | Load strobe, honoured while idle |
| ld_idx | input | 5 | Load register index |
| ld_data | input | 32 | Load data |
| peek_idx | input | 5 | Peek register index |
| peek_data | output | 32 | Contents of the peeked register |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request rejected, valid with done |

## Verification
A wrong element counter or stop condition shows up as done arriving a cycle early or late, which the bench measures on every request. It also leaves a register left unchanged or overwritten, seen at the peek port as soon as done falls. A mis-stepped operand index corrupts the accumulator or the prefix chain at the next element, and the full register file is compared after each request. Legality errors show up on illegal and done in the cycle after acceptance, and as any register that differs from its preloaded value.

// File: rtl/red_pkg.sv
package red_pkg;

    localparam int REG_N  = 32;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(REG_N);
    localparam int VL_W   = IDX_W + 1;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MIN = 3'd5,
        OP_MAX = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vec;
    } lane_t;

    typedef struct packed {
        lane_t lane;
        logic  cls;
    } operand_t;

    typedef struct packed {
        op_e   op;
        lane_t t;
        lane_t a;
        lane_t b;
    } exec_t;

    function automatic logic op_known(op_e o);
        return o != OP_RSV;
    endfunction

    // true when a vector lane of n elements would run past the last register
    function automatic logic span_bad(lane_t l, logic [VL_W-1:0] n);
        logic [VL_W:0] top;
        top = (VL_W+1)'(l.idx) + (VL_W+1)'(n);
        return l.vec && (n != '0) && (top > (VL_W+1)'(REG_N));
    endfunction

    function automatic logic [IDX_W-1:0] lane_reg(lane_t l, logic [VL_W-1:0] e);
        return l.idx + (l.vec ? e[IDX_W-1:0] : '0);
    endfunction

endpackage

// File: rtl/red_regfile.sv
module red_regfile
    import red_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  pk_addr,
    output logic [DATA_W-1:0] pk_data
);

    logic [DATA_W-1:0] mem [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign pk_data = mem[pk_addr];

endmodule

// File: rtl/red_alu.sv
module red_alu
    import red_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    logic a_lt_b;

    assign a_lt_b = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_MIN:  y = a_lt_b ? a : b;
            OP_MAX:  y = a_lt_b ? b : a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/red_seq.sv
module red_seq
    import red_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  op_e              op,
    input  operand_t         dst,
    input  operand_t         srca,
    input  operand_t         srcb,
    input  logic             mapreduce,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             issue,
    output op_e              op_o,
    output logic [IDX_W-1:0] t_reg,
    output logic [IDX_W-1:0] a_reg,
    output logic [IDX_W-1:0] b_reg
);

    st_e             st_q;
    exec_t           ex_q;
    logic            mr_q;
    logic            ill_q;
    logic [VL_W-1:0] elem_q;
    logic [VL_W-1:0] last_q;

    logic            req_bad;
    logic [VL_W-1:0] issue_n;

    // number of element operations a request asks for
    always_comb begin
        if (vl == '0) begin
            issue_n = '0;
        end else if (dst.lane.vec || mapreduce) begin
            issue_n = vl;
        end else begin
            issue_n = VL_W'(1);
        end
    end

    assign req_bad = !op_known(op)
                   || dst.cls || srca.cls || srcb.cls
                   || span_bad(dst.lane, vl)
                   || span_bad(srca.lane, vl)
                   || span_bad(srcb.lane, vl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ex_q   <= '0;
            mr_q   <= 1'b0;
            ill_q  <= 1'b0;
            elem_q <= '0;
            last_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        ex_q   <= '{op: op, t: dst.lane, a: srca.lane, b: srcb.lane};
                        mr_q   <= mapreduce;
                        ill_q  <= req_bad;
                        elem_q <= '0;
                        last_q <= issue_n - VL_W'(1);
                        st_q   <= (req_bad || issue_n == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (elem_q == last_q) begin
                        st_q <= ST_FIN;
                    end else begin
                        elem_q <= elem_q + VL_W'(1);
                    end
                end
                default: begin
                    st_q  <= ST_IDLE;
                    ill_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy    = st_q != ST_IDLE;
    assign done    = st_q == ST_FIN;
    assign illegal = done && ill_q;
    assign issue   = st_q == ST_RUN;
    assign op_o    = ex_q.op;
    assign t_reg   = lane_reg(ex_q.t, elem_q);
    assign a_reg   = lane_reg(ex_q.a, elem_q);
    assign b_reg   = lane_reg(ex_q.b, elem_q);

    // a scalar destination without mapreduce never reaches element 1
    assert_scalar_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (issue && elem_q != '0) |-> (ex_q.t.vec || mr_q));

    // consecutive issue cycles step the element by exactly one
    assert_program_order_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && $past(st_q) == ST_RUN) |-> (elem_q == $past(elem_q) + VL_W'(1)));

    // a rejected request never passes through the issue state
    assert_reject_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (done && ill_q) |-> ($past(st_q) == ST_IDLE));

    // vector destination writes stay inside the register file
    assert_span_R6: assert property (@(posedge clk) disable iff (rst)
        (issue && ex_q.t.vec) |->
        (((VL_W+1)'(ex_q.t.idx) + (VL_W+1)'(elem_q)) < (VL_W+1)'(REG_N)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // the latched request is frozen while elements are being issued
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        issue |=> ($stable(ex_q) && $stable(mr_q)));

endmodule

// File: rtl/red_reduce_seq.sv
module red_reduce_seq
    import red_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [2:0]        opcode,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              dst_vec,
    input  logic              dst_cls,
    input  logic [IDX_W-1:0]  srca_idx,
    input  logic              srca_vec,
    input  logic              srca_cls,
    input  logic [IDX_W-1:0]  srcb_idx,
    input  logic              srcb_vec,
    input  logic              srcb_cls,
    input  logic              mapreduce,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data,
    output logic              busy,
    output logic              done,
    output logic              illegal
);

    operand_t          dst_op, srca_op, srcb_op;
    logic              issue;
    op_e               ex_op;
    logic [IDX_W-1:0]  t_reg, a_reg, b_reg;
    logic [DATA_W-1:0] a_val, b_val, alu_y;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    assign dst_op  = '{lane: '{idx: dst_idx,  vec: dst_vec},  cls: dst_cls};
    assign srca_op = '{lane: '{idx: srca_idx, vec: srca_vec}, cls: srca_cls};
    assign srcb_op = '{lane: '{idx: srcb_idx, vec: srcb_vec}, cls: srcb_cls};

    red_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl        (vl),
        .op        (op_e'(opcode)),
        .dst       (dst_op),
        .srca      (srca_op),
        .srcb      (srcb_op),
        .mapreduce (mapreduce),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .issue     (issue),
        .op_o      (ex_op),
        .t_reg     (t_reg),
        .a_reg     (a_reg),
        .b_reg     (b_reg)
    );

    red_alu u_alu (
        .op (ex_op),
        .a  (a_val),
        .b  (b_val),
        .y  (alu_y)
    );

    // element results own the write port; loads only while idle
    always_comb begin
        if (issue) begin
            rf_we    = 1'b1;
            rf_waddr = t_reg;
            rf_wdata = alu_y;
        end else begin
            rf_we    = ld_en && !busy;
            rf_waddr = ld_idx;
            rf_wdata = ld_data;
        end
    end

    red_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra_addr (a_reg),
        .ra_data (a_val),
        .rb_addr (b_reg),
        .rb_data (b_val),
        .pk_addr (peek_idx),
        .pk_data (peek_data)
    );

endmodule

// File: tb/red_reduce_seq_bench.sv
module red_reduce_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  vl = '0;
    logic [2:0]  opcode = '0;
    logic [4:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0;
    logic        dst_vec = 1'b0, srca_vec = 1'b0, srcb_vec = 1'b0;
    logic        dst_cls = 1'b0, srca_cls = 1'b0, srcb_cls = 1'b0;
    logic        mapreduce = 1'b0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic        busy, done, illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    red_reduce_seq u_red_reduce_seq (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .opcode(opcode),
        .dst_idx(dst_idx), .dst_vec(dst_vec), .dst_cls(dst_cls),
        .srca_idx(srca_idx), .srca_vec(srca_vec), .srca_cls(srca_cls),
        .srcb_idx(srcb_idx), .srcb_vec(srcb_vec), .srcb_cls(srcb_cls),
        .mapreduce(mapreduce), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .busy(busy), .done(done), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return ($signed(a) < $signed(b)) ? a : b;
            3'd6: return ($signed(a) > $signed(b)) ? a : b;
            default: return a;
        endcase
    endfunction

    function automatic bit over_end(input logic [4:0] base, input bit v, input int n);
        return v && n != 0 && (int'(base) + n > NR);
    endfunction

    task automatic load_pattern(input int seed);
        for (int r = 0; r < NR; r++) begin
            logic [31:0] val;
            val = 32'(seed) * 32'h9E37_79B1 + 32'(r) * 32'h0100_0193 ^ (32'(r) << 27);
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 5'(r); ld_data = val;
            model[r] = val;
            @(posedge clk);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < NR; r++) begin
            peek_idx = 5'(r);
            #1;
            check(tag, peek_data, model[r]);
        end
    endtask

    task automatic run(input string tag, input logic [2:0] o, input int n,
                       input logic [4:0] t, input bit tv, input bit tc,
                       input logic [4:0] a, input bit av, input bit ac,
                       input logic [4:0] b, input bit bv, input bit bc,
                       input bit mr, input bit poke);
        bit ill_exp;
        int issue_exp;
        int cyc;
        ill_exp = (o == 3'd7) || tc || ac || bc
                || over_end(t, tv, n) || over_end(a, av, n) || over_end(b, bv, n);
        if (ill_exp || n == 0) issue_exp = 0;
        else if (tv || mr)     issue_exp = n;
        else                   issue_exp = 1;
        for (int i = 0; i < issue_exp; i++) begin
            logic [4:0] ti, ai, bi;
            ti = t + (tv ? 5'(i) : 5'd0);
            ai = a + (av ? 5'(i) : 5'd0);
            bi = b + (bv ? 5'(i) : 5'd0);
            model[ti] = ref_op(o, model[ai], model[bi]);
        end
        @(negedge clk);
        opcode = o; vl = 6'(n);
        dst_idx = t; dst_vec = tv; dst_cls = tc;
        srca_idx = a; srca_vec = av; srca_cls = ac;
        srcb_idx = b; srcb_vec = bv; srcb_cls = bc;
        mapreduce = mr;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        check({tag, " R10 busy after accept"}, 32'(busy), 32'd1);
        while (!done && cyc < 100) begin
            if (poke && cyc == 1) begin
                start = 1'b1; opcode = 3'd4; dst_vec = 1'b1; vl = 6'd3; srcb_idx = 5'd0;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check({tag, " R10 done latency"}, 32'(cyc), 32'(issue_exp));
        check({tag, " R5/R6 illegal flag"}, 32'(illegal), 32'(ill_exp));
        @(posedge clk);
        @(negedge clk);
        check({tag, " R10 done single pulse"}, 32'(done), 32'd0);
        check({tag, " R10 busy cleared"}, 32'(busy), 32'd0);
        check_regs({tag, " registers"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int vls [5];
        string tg;
        vls = '{0, 1, 2, 5, 8};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        for (int r = 0; r < NR; r++) model[r] = '0;
        check("R12 busy", 32'(busy), 32'd0);
        check("R12 done", 32'(done), 32'd0);
        check("R12 illegal", 32'(illegal), 32'd0);
        check_regs("R12 regs zero");
        // R13: load and peek
        load_pattern(7);
        check_regs("R13 load/peek");

        for (int o = 0; o < 7; o++) begin
            for (int k = 0; k < 5; k++) begin
                int n;
                n = vls[k];
                load_pattern(o * 8 + k + 1);
                if (n == 0)      tg = "R7";
                else if (o == 0) tg = "R1";
                else if (o == 1) tg = "R4";
                else             tg = "R9";
                run({tg, " accumulate"}, 3'(o), n, 5'd3, 0, 0, 5'd3, 0, 0, 5'd10, 1, 0, 1'b1, 1'b0);
                run(n == 0 ? "R7 no-mapreduce" : "R2 no-mapreduce",
                    3'(o), n, 5'd3, 0, 0, 5'd3, 0, 0, 5'd10, 1, 0, 1'b0, 1'b0);
                run(n == 0 ? "R7 vector dest" : "R8 vector dest",
                    3'(o), n, 5'd20, 1, 0, 5'd4, 1, 0, 5'd12, 1, 0, n[0], 1'b0);
                run("R8 scalar-b vector dest",
                    3'(o), n, 5'd24, 1, 0, 5'd2, 1, 0, 5'd9, 0, 0, 1'b0, 1'b0);
            end
        end

        load_pattern(99);
        // R3: prefix chain, each element reads the previous element's write
        run("R3 ordered chain", 3'd0, 8, 5'd1, 1, 0, 5'd0, 1, 0, 5'd16, 1, 0, 1'b0, 1'b0);
        run("R3 ordered sub chain", 3'd1, 6, 5'd9, 1, 0, 5'd8, 1, 0, 5'd20, 1, 0, 1'b1, 1'b0);
        // R5: class mismatches
        run("R5 cls srcb", 3'd0, 4, 5'd3, 0, 0, 5'd3, 0, 0, 5'd10, 1, 1, 1'b1, 1'b0);
        run("R5 cls dst",  3'd0, 4, 5'd3, 0, 1, 5'd3, 0, 0, 5'd10, 1, 0, 1'b1, 1'b0);
        run("R5 cls srca", 3'd2, 4, 5'd20, 1, 0, 5'd4, 1, 1, 5'd10, 1, 0, 1'b0, 1'b0);
        // R6: range and opcode legality
        run("R6 over end", 3'd0, 5, 5'd3, 0, 0, 5'd3, 0, 0, 5'd28, 1, 0, 1'b1, 1'b0);
        run("R6 dst over end", 3'd0, 4, 5'd30, 1, 0, 5'd0, 1, 0, 5'd8, 1, 0, 1'b0, 1'b0);
        run("R6 at boundary", 3'd0, 5, 5'd3, 0, 0, 5'd3, 0, 0, 5'd27, 1, 0, 1'b1, 1'b0);
        run("R6 reserved op", 3'd7, 3, 5'd3, 0, 0, 5'd3, 0, 0, 5'd10, 1, 0, 1'b1, 1'b0);
        run("R6 full length", 3'd4, 32, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 1'b1, 1'b0);
        // R11: start during busy is ignored
        load_pattern(123);
        run("R11 start ignored", 3'd0, 6, 5'd3, 0, 0, 5'd3, 0, 0, 5'd10, 1, 0, 1'b1, 1'b1);
        run("R11 start ignored vec", 3'd6, 5, 5'd20, 1, 0, 5'd4, 1, 0, 5'd12, 1, 0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule